// File: doc/BRIEF.md
# Dual-Source Capture Buffer

This block is an 8 KB on-chip store that keeps whichever of two data streams a storage command last produced. It holds either the identification data returned by an Identify command or a rolling window of the data returned by a Read command. Data comes in as 128-bit beats with a valid strobe. A one-cycle start pulse, which carries a two-bit command code, marks the beginning of each command.

Each start pulse for a capturing command sends the write pointer back to beat 0. Every accepted beat then advances the pointer by one. When a transfer is longer than the buffer, the pointer wraps and the newest beats overwrite the oldest ones. Write commands and the reserved code turn capture off, so the contents stay as they were.

A separate CPU-side port reads one 32-bit word per access with a fixed latency of one clock. A bus bridge maps the 2048 words into a 0x2000-byte window of the register space. The port is meant for low-rate inspection, not bulk transfer.

Top module: `dual_src_capture_buf`

## Requirements
- R1: The store holds 512 beats of 128 bits (8 KB). `cpu_rd_addr` is an 11-bit word index, so word 2047 returns bits [127:96] of beat 511.
- R2: A `cmd_start` pulse with `cmd_kind` 2'b00 (Identify) or 2'b11 (Read) turns capture on. The first beat accepted after it is stored at beat 0.
- R3: Each beat accepted while capture is on is written at the current pointer, and the pointer then advances by one. It wraps from 511 to 0, so beat k of a command ends up at beat k mod 512 and later beats replace earlier ones.
- R4: A `cmd_start` pulse with `cmd_kind` 2'b10 (Write) or 2'b01 (reserved) turns capture off. Beats that follow leave the stored contents unchanged until the next Identify or Read start.
- R5: CPU word w returns bits [32*(w mod 4)+31 : 32*(w mod 4)] of beat w/4, with the lowest-order 32 bits at the lowest word index.
- R6: `cpu_rd_valid` is high exactly in the cycle after a cycle with `cpu_rd_en` high, and `cpu_rd_data` carries the addressed word in that cycle.
- R7: When a CPU read and a beat write hit the same beat in the same cycle, the read returns the contents from before that write.
- R8: After reset, capture is off and `cpu_rd_valid` is low. Reset does not clear the stored contents, and beats that arrive before the first capturing start pulse are not stored.
- R9: A beat whose valid is high in the same cycle as `cmd_start` is dropped. The next accepted beat still goes to beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | One-cycle pulse at the start of each storage command |
| cmd_kind | input | 2 | Command code sampled with `cmd_start`: 00 Identify, 10 Write, 11 Read, 01 reserved |
| beat_valid | input | 1 | Incoming beat strobe |
| beat_data | input | 128 | Incoming beat, one 16-byte unit |
| cpu_rd_en | input | 1 | CPU read request, one word per cycle |
| cpu_rd_addr | input | 11 | CPU word index into the buffer |
| cpu_rd_data | output | 32 | Returned word, valid with `cpu_rd_valid` |
| cpu_rd_valid | output | 1 | High one cycle after each read request |

## Verification
The capture path is exercised with a series of commands of varied type and length. Short Identify and Read transfers show that the pointer restarts at beat 0. Transfers of exactly 512 beats and of 520 and 600 beats separate wrap-and-overwrite from a pointer that saturates or never returns to zero. Write and reserved commands placed between capturing ones show whether beats leak into the store, because each beat encodes its command number, lane and beat index, and a misplaced, stale or lane-swapped word therefore shows up as a mismatch. Directed cases cover the same-cycle read/write collision, a beat that arrives with the start pulse, the top word of the address range, and contents that survive a reset.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [1:0] {
    CMD_IDENT = 2'b00,
    CMD_RSVD  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_READ  = 2'b11
  } cap_cmd_e;

  // True for the command codes whose returned data is kept in the buffer.
  function automatic logic is_capture(input logic [1:0] kind);
    return (kind == CMD_IDENT) || (kind == CMD_READ);
  endfunction

endpackage

// File: rtl/cap_wr_ctrl.sv
module cap_wr_ctrl #(
  parameter int PTR_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_start,
  input  logic [1:0]       cmd_kind,
  input  logic             beat_valid,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic             cap_on
);
  import cap_pkg::*;

  // A start pulse has priority: any beat presented with it is dropped.
  assign wr_en = beat_valid && cap_on && !cmd_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_on <= 1'b0;
      wr_ptr <= '0;
    end else if (cmd_start) begin
      cap_on <= is_capture(cmd_kind);
      wr_ptr <= '0;
    end else if (wr_en) begin
      wr_ptr <= wr_ptr + 1'b1;  // natural wrap at 2**PTR_W
    end
  end

endmodule

// File: rtl/cap_lane_ram.sv
module cap_lane_ram #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 9,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Simple dual-port, read-first: a same-address read sees the old word.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/cap_rd_port.sv
module cap_rd_port #(
  parameter int LANES  = 4,
  parameter int WORD_W = 32,
  parameter int SEL_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_en,
  input  logic [SEL_W-1:0]        lane_sel,
  input  logic [LANES*WORD_W-1:0] lane_q,
  output logic [WORD_W-1:0]       rd_data,
  output logic                    rd_valid
);

  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      sel_q    <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) sel_q <= lane_sel;
    end
  end

  // Lane outputs are already registered inside the RAMs; only a mux follows.
  assign rd_data = lane_q[sel_q*WORD_W +: WORD_W];

endmodule

// File: rtl/dual_src_capture_buf.sv
module dual_src_capture_buf #(
  parameter int BEAT_W    = 128,
  parameter int WORD_W    = 32,
  parameter int BUF_BYTES = 8192,
  localparam int LANES    = BEAT_W / WORD_W,
  localparam int ENTRIES  = BUF_BYTES / (BEAT_W / 8),
  localparam int PTR_W    = $clog2(ENTRIES),
  localparam int SEL_W    = $clog2(LANES),
  localparam int ADDR_W   = PTR_W + SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic [1:0]        cmd_kind,
  input  logic              beat_valid,
  input  logic [BEAT_W-1:0] beat_data,
  input  logic              cpu_rd_en,
  input  logic [ADDR_W-1:0] cpu_rd_addr,
  output logic [WORD_W-1:0] cpu_rd_data,
  output logic              cpu_rd_valid
);

  logic                    wr_en;
  logic [PTR_W-1:0]        wr_ptr;
  logic                    cap_on;
  logic [LANES-1:0]        rd_lane_en;
  logic [LANES*WORD_W-1:0] lane_q;

  cap_wr_ctrl #(.PTR_W(PTR_W)) i_wr (
    .clk        (clk),
    .rst        (rst),
    .cmd_start  (cmd_start),
    .cmd_kind   (cmd_kind),
    .beat_valid (beat_valid),
    .wr_en      (wr_en),
    .wr_ptr     (wr_ptr),
    .cap_on     (cap_on)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_lane_en[g] = cpu_rd_en && (cpu_rd_addr[SEL_W-1:0] == SEL_W'(g));

    cap_lane_ram #(.DATA_W(WORD_W), .ADDR_W(PTR_W)) i_ram (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_ptr),
      .wdata (beat_data[g*WORD_W +: WORD_W]),
      .re    (rd_lane_en[g]),
      .raddr (cpu_rd_addr[ADDR_W-1:SEL_W]),
      .rdata (lane_q[g*WORD_W +: WORD_W])
    );
  end

  cap_rd_port #(.LANES(LANES), .WORD_W(WORD_W), .SEL_W(SEL_W)) i_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (cpu_rd_en),
    .lane_sel (cpu_rd_addr[SEL_W-1:0]),
    .lane_q   (lane_q),
    .rd_data  (cpu_rd_data),
    .rd_valid (cpu_rd_valid)
  );

endmodule

// File: rtl/dual_src_capture_buf_chk.sv
module dual_src_capture_buf_chk #(
  parameter int PTR_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_start,
  input logic [1:0]       cmd_kind,
  input logic             cpu_rd_en,
  input logic             cpu_rd_valid,
  input logic             wr_en,
  input logic [PTR_W-1:0] wr_ptr,
  input logic             cap_on
);

  // R6: the valid strobe follows a request by exactly one clock
  a_r6_valid_after_req: assert property (@(posedge clk) disable iff (rst)
    cpu_rd_en |=> cpu_rd_valid);
  a_r6_no_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd_en |=> !cpu_rd_valid);

  // R2: a capturing start sends the pointer home and enables capture
  a_r2_ptr_home: assert property (@(posedge clk) disable iff (rst)
    cmd_start |=> (wr_ptr == '0));
  a_r2_capture_on: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && (cmd_kind == 2'b00 || cmd_kind == 2'b11)) |=> cap_on);

  // R3: each stored beat moves the pointer by one, modulo the depth
  a_r3_ptr_step: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (wr_ptr == PTR_W'($past(wr_ptr) + 1'b1)));

  // R4: write and reserved codes disable capture
  a_r4_capture_off: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && (cmd_kind == 2'b10 || cmd_kind == 2'b01)) |=> !cap_on);

  // R4 / R8: with capture off and no start, the pointer stays put
  a_r8_ptr_frozen: assert property (@(posedge clk) disable iff (rst)
    (!cap_on && !cmd_start) |=> $stable(wr_ptr));

endmodule

bind dual_src_capture_buf dual_src_capture_buf_chk #(.PTR_W(PTR_W)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .cmd_start    (cmd_start),
  .cmd_kind     (cmd_kind),
  .cpu_rd_en    (cpu_rd_en),
  .cpu_rd_valid (cpu_rd_valid),
  .wr_en        (wr_en),
  .wr_ptr       (wr_ptr),
  .cap_on       (cap_on)
);

// File: tb/test_dual_src_capture_buf.sv
`timescale 1ns/1ps
module test_dual_src_capture_buf;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_start = 1'b0;
  logic [1:0]   cmd_kind = 2'b00;
  logic         beat_valid = 1'b0;
  logic [127:0] beat_data = '0;
  logic         cpu_rd_en = 1'b0;
  logic [10:0]  cpu_rd_addr = '0;
  logic [31:0]  cpu_rd_data;
  logic         cpu_rd_valid;

  always #2.5 clk = ~clk;  // 200 MHz

  dual_src_capture_buf i_dual_src_capture_buf (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_kind(cmd_kind),
    .beat_valid(beat_valid), .beat_data(beat_data),
    .cpu_rd_en(cpu_rd_en), .cpu_rd_addr(cpu_rd_addr),
    .cpu_rd_data(cpu_rd_data), .cpu_rd_valid(cpu_rd_valid)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Independent model of the store
  logic [127:0] shadow [512];
  int  bptr = 0;
  bit  cap_model = 0;
  int  cmd_no = 0;

  // Command table: code, beat count, probe word
  localparam int NROW = 8;
  localparam int T_KIND  [NROW] = '{0, 3, 2, 3, 1, 0, 3, 3};
  localparam int T_BEATS [NROW] = '{4, 10, 6, 600, 5, 1, 2, 520};
  localparam int T_PROBE [NROW] = '{13, 36, 39, 350, 350, 1, 7, 28};
  // rows: R2 identify, R2 read, R4 write, R3 wrap, R4 reserved, R2, R5, R3

  function automatic logic [127:0] beat_val(input int cid, input int idx);
    logic [127:0] v;
    for (int l = 0; l < 4; l++) v[32*l +: 32] = {cid[7:0], 4'(l), idx[19:0]};
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cap_model = 0; bptr = 0;
  endtask

  task automatic start_cmd(input int kind);
    @(negedge clk);
    cmd_start = 1'b1; cmd_kind = 2'(kind);
    @(negedge clk);
    cmd_start = 1'b0;
    cmd_no++;
    cap_model = (kind == 0 || kind == 3);
    bptr = 0;
  endtask

  task automatic send_beats(input int n);
    for (int i = 0; i < n; i++) begin
      beat_valid = 1'b1;
      beat_data  = beat_val(cmd_no, i);
      if (cap_model) begin
        shadow[bptr] = beat_data;
        bptr = (bptr + 1) % 512;
      end
      @(negedge clk);
    end
    beat_valid = 1'b0;
  endtask

  task automatic cpu_read(input int addr, output logic [31:0] d, output logic v);
    cpu_rd_en = 1'b1; cpu_rd_addr = 11'(addr);
    @(negedge clk);
    cpu_rd_en = 1'b0;
    d = cpu_rd_data; v = cpu_rd_valid;
  endtask

  function automatic logic [31:0] exp_word(input int addr);
    return shadow[addr/4][32*(addr%4) +: 32];
  endfunction

  initial begin : watchdog
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin : main
    logic [31:0] d;
    logic v;
    logic [127:0] old0, e_beat;

    do_reset();
    // R8: no valid after reset
    check(cpu_rd_valid == 1'b0, "R8 reset valid", 32'(cpu_rd_valid), 32'd0);

    // Table walk
    for (int r = 0; r < NROW; r++) begin
      start_cmd(T_KIND[r]);
      send_beats(T_BEATS[r]);
      cpu_read(T_PROBE[r], d, v);
      check(v && d == exp_word(T_PROBE[r]), $sformatf("R%0d table row %0d", (r == 3 || r == 7) ? 3 : 2, r),
            d, exp_word(T_PROBE[r]));
    end

    // R6: latency and strobe shape
    cpu_rd_en = 1'b1; cpu_rd_addr = 11'd0;
    @(negedge clk);
    cpu_rd_en = 1'b0;
    check(cpu_rd_valid == 1'b1, "R6 valid after request", 32'(cpu_rd_valid), 32'd1);
    check(cpu_rd_data == exp_word(0), "R6 data with valid", cpu_rd_data, exp_word(0));
    @(negedge clk);
    check(cpu_rd_valid == 1'b0, "R6 valid drops", 32'(cpu_rd_valid), 32'd0);

    // R5: lane order within one beat
    start_cmd(0);
    send_beats(1);
    for (int w = 0; w < 4; w++) begin
      cpu_read(w, d, v);
      check(d == {cmd_no[7:0], 4'(w), 20'd0}, "R5 lane order", d, {cmd_no[7:0], 4'(w), 20'd0});
    end

    // R1 / R3: exactly 512 beats fills top word, then wrap lands at 0
    start_cmd(3);
    send_beats(512);
    cpu_read(2047, d, v);
    check(d == {cmd_no[7:0], 4'd3, 20'd511}, "R1 top word", d, {cmd_no[7:0], 4'd3, 20'd511});
    cpu_read(0, d, v);
    check(d == {cmd_no[7:0], 4'd0, 20'd0}, "R3 no early wrap", d, {cmd_no[7:0], 4'd0, 20'd0});

    // R7: read and write of beat 0 in the same cycle
    start_cmd(3);
    old0 = shadow[0];
    e_beat = beat_val(cmd_no, 0);
    beat_valid = 1'b1; beat_data = e_beat;
    cpu_rd_en = 1'b1; cpu_rd_addr = 11'd2;
    @(negedge clk);
    beat_valid = 1'b0; cpu_rd_en = 1'b0;
    shadow[0] = e_beat; bptr = 1;
    check(cpu_rd_data == old0[95:64], "R7 collision returns old", cpu_rd_data, old0[95:64]);
    cpu_read(2, d, v);
    check(d == e_beat[95:64], "R7 new data after", d, e_beat[95:64]);

    // R9: beat presented with the start pulse is dropped
    @(negedge clk);
    cmd_start = 1'b1; cmd_kind = 2'b11;
    beat_valid = 1'b1; beat_data = {4{32'hDEAD_0009}};
    @(negedge clk);
    cmd_start = 1'b0; cmd_no++; cap_model = 1; bptr = 0;
    send_beats(1);
    cpu_read(0, d, v);
    check(d == exp_word(0), "R9 start beat dropped", d, exp_word(0));

    // R8: reset keeps contents, beats before a capturing start are not stored
    do_reset();
    check(cpu_rd_valid == 1'b0, "R8 valid after second reset", 32'(cpu_rd_valid), 32'd0);
    cmd_no++;
    send_beats(3);
    cpu_read(0, d, v);
    check(d == exp_word(0), "R8 pre-command beats ignored", d, exp_word(0));
    cpu_read(5, d, v);
    check(d == exp_word(5), "R8 contents kept over reset", d, exp_word(5));

    // R4: write command then long burst leaves wrapped region untouched
    start_cmd(2);
    send_beats(20);
    cpu_read(4*19 + 1, d, v);
    check(d == exp_word(4*19 + 1), "R4 write burst ignored", d, exp_word(4*19 + 1));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule